// File: doc/BRIEF.md
# Bit-Vector Multi-Field Prefix Classifier

This block sorts packet headers into rules by looking at several header fields independently. For every field it compares the packet's value against the stored prefix of every rule at once. This yields one bit per rule, set where that rule's prefix covers the packet's field. The per-field vectors are then intersected with a bitwise AND, so a bit survives only for rules that agree on every field. The lowest surviving index is reported as the winning rule, which gives lower indices higher priority.

Rules are written through a small configuration port, one field of one rule per write. Each write stores a value, a prefix length and an active flag for that rule. Lookups are presented with a valid strobe. The classification result, a hit flag and a rule index, appears registered on the following clock.

Top module: `pfxc_top`

## Requirements
- R1: After reset `out_valid` is low and every rule is inactive, so a lookup made before any configuration write returns `out_hit`=0.
- R2: Field f of `in_key` occupies bits [f*FIELD_W +: FIELD_W]. A rule field with prefix length L matches when the L most significant bits of that key field equal the L most significant bits of the stored value.
- R3: A stored prefix length of 0 matches every key value in that field.
- R4: A rule matches only when it is active and its prefix matches in every field.
- R5: When several rules match, the reported index is the lowest matching one.
- R6: When no rule matches, `out_hit` is 0 and `out_idx` is 0.
- R7: Every cycle with `in_valid` high produces exactly one result with `out_valid` high on the next cycle, for that cycle's key. `out_valid` is low in every other cycle.
- R8: A cycle with `cfg_we` high stores `cfg_val` and `cfg_len` for field `cfg_field` of rule `cfg_rule`, and sets that rule's active flag to `cfg_act`. Lookups presented from the next cycle onward use the new contents.
- R9: With two 2-bit fields, rules 0 to 8 loaded as 00/00, 00/01, 10/11, 11/10, 0/10, 11/11, 0/0, 10/01, 1/01 (field 0 / field 1, the digit count being the prefix length) and the other rules inactive, all 16 keys classify to the lowest matching rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rule | input | $clog2(NUM_RULES) | Rule being written |
| cfg_field | input | max(1,$clog2(NUM_FIELDS)) | Field being written |
| cfg_val | input | FIELD_W | Prefix value, MSB-aligned |
| cfg_len | input | $clog2(FIELD_W+1) | Prefix length in bits |
| cfg_act | input | 1 | Active flag stored for the rule |
| in_valid | input | 1 | Lookup strobe |
| in_key | input | NUM_FIELDS*FIELD_W | Concatenated header fields |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_hit | output | 1 | A rule matched |
| out_idx | output | $clog2(NUM_RULES) | Lowest matching rule index |

## Verification
The bench builds the block with two fields of 2 bits and 16 rules. This makes the whole key space of 16 values small enough to sweep completely against the nine-rule reference set, with seven spare rules left for wildcard and intersection cases. The narrow fields put every prefix length from 0 to full width, and every priority overlap among the reference rules, within a few dozen lookups. Deactivating and rewriting rules between sweeps exercises the configuration path.

// File: rtl/pfxc_pkg.sv
package pfxc_pkg;

    localparam int unsigned PFXC_MAX_W = 32;

    // Mask with the 'len' most significant bits of a 'w'-bit field set.
    function automatic logic [PFXC_MAX_W-1:0] lead_mask(input int unsigned w,
                                                        input int unsigned len);
        logic [PFXC_MAX_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < PFXC_MAX_W; b++) begin
            if (b < w && (b + len) >= w) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pfxc_rule_store.sv
module pfxc_rule_store #(
    parameter int unsigned NR  = 16,
    parameter int unsigned NF  = 2,
    parameter int unsigned FW  = 8,
    parameter int unsigned LW  = 4,
    parameter int unsigned RIW = 4,
    parameter int unsigned FIW = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [RIW-1:0]             cfg_rule,
    input  logic [FIW-1:0]             cfg_field,
    input  logic [FW-1:0]              cfg_val,
    input  logic [LW-1:0]              cfg_len,
    input  logic                       cfg_act,
    output logic [NR-1:0]              act_o,
    output logic [NR*NF-1:0][FW-1:0]   val_o,
    output logic [NR*NF-1:0][LW-1:0]   len_o
);

    typedef struct packed {
        logic [NR-1:0]            act;
        logic [NR*NF-1:0][FW-1:0] val;
        logic [NR*NF-1:0][LW-1:0] len;
    } store_t;

    store_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we && (32'(cfg_rule) < NR) && (32'(cfg_field) < NF)) begin
            state_d.act[cfg_rule]                          = cfg_act;
            state_d.val[32'(cfg_rule) * NF + 32'(cfg_field)] = cfg_val;
            state_d.len[32'(cfg_rule) * NF + 32'(cfg_field)] = cfg_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign act_o = state_q.act;
    assign val_o = state_q.val;
    assign len_o = state_q.len;

    AST_CFG_LEN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_rule) < NR) && (32'(cfg_field) < NF)) |=>
        (state_q.len[$past(32'(cfg_rule)) * NF + $past(32'(cfg_field))] == $past(cfg_len)
         && state_q.act[$past(cfg_rule)] == $past(cfg_act))); // R8

endmodule

// File: rtl/pfxc_field_match.sv
module pfxc_field_match
    import pfxc_pkg::*;
#(
    parameter int unsigned NR = 16,
    parameter int unsigned FW = 8,
    parameter int unsigned LW = 4
) (
    input  logic [FW-1:0]          key,
    input  logic [NR-1:0][FW-1:0]  val,
    input  logic [NR-1:0][LW-1:0]  len,
    output logic [NR-1:0]          vec
);

    always_comb begin
        logic [PFXC_MAX_W-1:0] m;
        for (int unsigned r = 0; r < NR; r++) begin
            m      = lead_mask(FW, 32'(len[r]));
            vec[r] = (((key ^ val[r]) & m[FW-1:0]) == '0);
        end
    end

endmodule

// File: rtl/pfxc_prio_enc.sv
module pfxc_prio_enc #(
    parameter int unsigned NR = 16,
    parameter int unsigned IW = 4
) (
    input  logic [NR-1:0] vec,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NR - 1; r >= 0; r--) begin
            if (vec[r]) begin
                hit = 1'b1;
                idx = IW'(r);
            end
        end
    end

endmodule

// File: rtl/pfxc_top.sv
module pfxc_top #(
    parameter int unsigned NUM_RULES  = 16,
    parameter int unsigned NUM_FIELDS = 2,
    parameter int unsigned FIELD_W    = 8,
    localparam int unsigned RIW = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
    localparam int unsigned FIW = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
    localparam int unsigned LW  = $clog2(FIELD_W + 1),
    localparam int unsigned KW  = NUM_FIELDS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIW-1:0]    cfg_rule,
    input  logic [FIW-1:0]    cfg_field,
    input  logic [FIELD_W-1:0] cfg_val,
    input  logic [LW-1:0]     cfg_len,
    input  logic              cfg_act,
    input  logic              in_valid,
    input  logic [KW-1:0]     in_key,
    output logic              out_valid,
    output logic              out_hit,
    output logic [RIW-1:0]    out_idx
);

    localparam int unsigned NR = NUM_RULES;
    localparam int unsigned NF = NUM_FIELDS;

    logic [NR-1:0]                 st_act;
    logic [NR*NF-1:0][FIELD_W-1:0] st_val;
    logic [NR*NF-1:0][LW-1:0]      st_len;
    logic [NF-1:0][NR-1:0]         field_vec;
    logic [NR-1:0]                 match_vec;
    logic                          enc_hit;
    logic [RIW-1:0]                enc_idx;

    pfxc_rule_store #(
        .NR(NR), .NF(NF), .FW(FIELD_W), .LW(LW), .RIW(RIW), .FIW(FIW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_rule(cfg_rule), .cfg_field(cfg_field),
        .cfg_val(cfg_val), .cfg_len(cfg_len), .cfg_act(cfg_act),
        .act_o(st_act), .val_o(st_val), .len_o(st_len)
    );

    for (genvar f = 0; f < NF; f++) begin : g_field
        logic [NR-1:0][FIELD_W-1:0] fv;
        logic [NR-1:0][LW-1:0]      fl;
        always_comb begin
            for (int unsigned r = 0; r < NR; r++) begin
                fv[r] = st_val[r * NF + f];
                fl[r] = st_len[r * NF + f];
            end
        end
        pfxc_field_match #(.NR(NR), .FW(FIELD_W), .LW(LW)) u_match (
            .key(in_key[f*FIELD_W +: FIELD_W]),
            .val(fv), .len(fl), .vec(field_vec[f])
        );
    end

    always_comb begin
        match_vec = st_act;
        for (int unsigned f = 0; f < NF; f++) match_vec &= field_vec[f];
    end

    pfxc_prio_enc #(.NR(NR), .IW(RIW)) u_enc (
        .vec(match_vec), .hit(enc_hit), .idx(enc_idx)
    );

    typedef struct packed {
        logic           valid;
        logic           hit;
        logic [RIW-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        if (in_valid && enc_hit) begin
            res_d.hit = 1'b1;
            res_d.idx = enc_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_hit   = res_q.hit;
    assign out_idx   = res_q.idx;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_MISS_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_idx == '0)); // R6
    AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        enc_hit |-> (match_vec[enc_idx] && ((match_vec & ((NR'(1) << enc_idx) - NR'(1))) == '0))); // R5
    AST_HIT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        enc_hit |-> st_act[enc_idx]); // R4

endmodule

// File: tb/pfxc_top_bench.sv
module pfxc_top_bench;

    localparam int NR = 16;
    localparam int NF = 2;
    localparam int FW = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_rule = '0;
    logic [0:0] cfg_field = '0;
    logic [1:0] cfg_val = '0;
    logic [1:0] cfg_len = '0;
    logic       cfg_act = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_key = '0;
    logic       out_valid;
    logic       out_hit;
    logic [3:0] out_idx;

    always #4 clk = ~clk;

    pfxc_top #(.NUM_RULES(NR), .NUM_FIELDS(NF), .FIELD_W(FW)) u_pfxc_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_rule(cfg_rule), .cfg_field(cfg_field),
        .cfg_val(cfg_val), .cfg_len(cfg_len), .cfg_act(cfg_act),
        .in_valid(in_valid), .in_key(in_key),
        .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx)
    );

    typedef struct {
        bit    hit;
        int    idx;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int pushed = 0;
    int popped = 0;

    int m_val[NR][NF];
    int m_len[NR][NF];
    bit m_act[NR];

    function automatic bit fld_ok(int key, int val, int len);
        int sh;
        if (len == 0) return 1'b1;
        sh = FW - len;
        return ((key >> sh) == (val >> sh));
    endfunction

    function automatic exp_t model(int key, string tag);
        exp_t e;
        e.hit = 1'b0; e.idx = 0; e.tag = tag;
        for (int r = NR - 1; r >= 0; r--) begin
            bit ok;
            ok = m_act[r];
            for (int f = 0; f < NF; f++)
                if (!fld_ok((key >> (f * FW)) & 3, m_val[r][f], m_len[r][f])) ok = 1'b0;
            if (ok) begin e.hit = 1'b1; e.idx = r; end
        end
        return e;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(int rule, int field, int val, int len, bit act);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rule = 4'(rule); cfg_field = 1'(field);
        cfg_val = 2'(val); cfg_len = 2'(len); cfg_act = act;
        m_val[rule][field] = val; m_len[rule][field] = len; m_act[rule] = act;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic add_rule(int rule, int v0, int l0, int v1, int l1);
        cfg_write(rule, 0, v0, l0, 1'b1);
        cfg_write(rule, 1, v1, l1, 1'b1);
    endtask

    // Drives one lookup for one cycle; caller drops in_valid with idle().
    task automatic lookup(int f0, int f1, string tag);
        int key;
        key = (f1 << FW) | f0;
        @(negedge clk);
        in_valid = 1'b1; in_key = 4'(key);
        q.push_back(model(key, tag));
        pushed++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check("R7 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                popped++;
                check({e.tag, " hit"}, int'(out_hit), int'(e.hit));
                check({e.tag, " idx"}, int'(out_idx), e.idx);
            end
        end
    end

    initial begin
        #(8 * 20000);
        check("watchdog expired", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_act[r] = 1'b0;
            for (int f = 0; f < NF; f++) begin m_val[r][f] = 0; m_len[r][f] = 0; end
        end
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid idle after reset", int'(out_valid), 0);

        // R1: nothing active yet, so wildcard-looking keys still miss
        lookup(0, 0, "R1 unconfigured");
        lookup(3, 3, "R1 unconfigured");
        idle(3);

        // R8/R9: load reference set into rules 0..8
        add_rule(0, 2'b00, 2, 2'b00, 2);
        add_rule(1, 2'b00, 2, 2'b01, 2);
        add_rule(2, 2'b10, 2, 2'b11, 2);
        add_rule(3, 2'b11, 2, 2'b10, 2);
        add_rule(4, 2'b00, 1, 2'b10, 2);
        add_rule(5, 2'b11, 2, 2'b11, 2);
        add_rule(6, 2'b00, 1, 2'b00, 1);
        add_rule(7, 2'b10, 2, 2'b01, 2);
        add_rule(8, 2'b10, 1, 2'b01, 2);

        // R9 + R7: full back-to-back sweep
        for (int k = 0; k < 16; k++) lookup(k & 3, k >> 2, "R9 reference sweep");
        idle(3);

        lookup(2'b00, 2'b00, "R5 rule0 beats rule6");
        lookup(2'b01, 2'b10, "R2 one-bit prefix rule4");
        lookup(2'b10, 2'b01, "R5 rule7 beats rule8");
        lookup(2'b01, 2'b11, "R6 no match");
        idle(1);
        lookup(2'b00, 2'b11, "R6 no match after gap");
        idle(3);

        // R3: wildcard field 0, exact field 1 = 11
        add_rule(9, 2'b10, 0, 2'b11, 2);
        lookup(2'b01, 2'b11, "R3 wildcard field0");
        lookup(2'b00, 2'b11, "R3 wildcard field0");
        idle(3);

        // R4: both fields must agree
        add_rule(10, 2'b11, 2, 2'b00, 2);
        lookup(2'b11, 2'b00, "R4 both fields match");
        lookup(2'b11, 2'b01, "R4 field1 mismatch");
        idle(3);

        // R8: deactivate rule 0, rule 6 takes over
        cfg_write(0, 1, 2'b00, 2, 1'b0);
        lookup(2'b00, 2'b00, "R8 rule0 deactivated");
        idle(3);

        // R3: fully wildcard rule 15 catches every former miss
        add_rule(15, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) lookup(k & 3, k >> 2, "R3 catch-all sweep");
        idle(4);

        check("R7 one result per lookup", popped, pushed);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule